// File: doc/BRIEF.md
# PHY Power and Operating State Controller

This block is the PHY-side mode controller of a synchronous MAC-to-PHY link. It holds the PHY in one of six operating states: RESET, SLEEP, STANDBY, READY, TRANSMIT and RECEIVE. It moves between them on three inputs. The first is a hard reset line from the MAC. The second is the pair of transmit and receive enables. The third is a two-bit power-mode code that the register file writes.

A single output line, `phy_active_o`, carries two handshakes. During reset it stays high until the internal reset work is finished, and it falls on entry to STANDBY. During a wake-up it rises when the PHY leaves SLEEP, and it stays high until the MAC has dropped both enables. The block also gives:
- a sticky ready flag for the control register;
- a "clock running" flag, which is low only in SLEEP;
- a qualifier that permits clear-channel reporting only after a programmable delay following the enable bit, and only in states where such reports make sense.

A power-mode write that arrives while a frame is being sent or received, or while the wake handshake is still open, is stored. It is applied as soon as the block is idle again.

Top module: `phy_pm_ctrl`

## Requirements
- R1: While `phy_reset_i` is high at a clock edge, the next state is RESET (`state_o` = 0) from any state, and `phy_active_o` is 1. Any stored power-mode request is discarded.
- R2: After `phy_reset_i` is sampled low at RST_CYC consecutive edges while in RESET, the state becomes STANDBY (`state_o` = 2) on the last of those edges, and `phy_active_o` falls in the same cycle. Before that edge the state is still RESET.
- R3: `rdy_o` is 0 in RESET. It is 1 from the completion of reset until the next reset.
- R4: In SLEEP (`state_o` = 1), TX and RX enable high together move the block to STANDBY with `phy_active_o` = 1. A single enable has no effect. `clk_run_o` is 0 exactly in SLEEP.
- R5: After a wake, `phy_active_o` stays 1 in STANDBY until both enables are low at an edge, and then it drops to 0.
- R6: A power-mode write (`pm_wr_i`) in SLEEP, STANDBY or READY moves the block at the next edge: code 00 gives READY (`state_o` = 3), 01 gives STANDBY and 10 gives SLEEP. Code 11 is ignored, and so is any write made in RESET.
- R7: In READY, TX enable alone gives TRANSMIT (`state_o` = 4) and RX enable alone gives RECEIVE (5). Both enables together leave READY unchanged. TRANSMIT returns to READY when TX enable is low, and RECEIVE returns to READY when RX enable is low.
- R8: A valid write made during TRANSMIT, RECEIVE or an open wake handshake is stored, and the latest one wins. It is applied at the first edge at which the block is idle, so READY is seen for one cycle before the stored target takes effect.
- R9: In an idle state, a write (new or stored) takes priority over the enables. A new write replaces a stored one in the same cycle. `phy_reset_i` overrides everything.
- R10: `cca_ok_o` rises after `ccre_i` has been sampled high at CCA_CYC consecutive edges. It falls at the first edge at which `ccre_i` is sampled low.
- R11: `cca_ok_o` is 1 only in READY or RECEIVE. It is never 1 in TRANSMIT, STANDBY, SLEEP or RESET.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge |
| rst | input | 1 | Synchronous active-high power-on reset (enters RESET) |
| phy_reset_i | input | 1 | Hard reset request from the MAC |
| tx_en_i | input | 1 | Transmit enable from the MAC |
| rx_en_i | input | 1 | Receive enable from the MAC |
| pm_wr_i | input | 1 | One-cycle strobe of a power-mode write |
| pm_mode_i | input | 2 | Power-mode code: 00 READY, 01 STANDBY, 10 SLEEP, 11 ignored |
| ccre_i | input | 1 | Clear-channel reporting enable bit |
| state_o | output | 3 | State: 0 RESET, 1 SLEEP, 2 STANDBY, 3 READY, 4 TRANSMIT, 5 RECEIVE |
| phy_active_o | output | 1 | Reset-done and wake handshake line |
| rdy_o | output | 1 | Ready flag for the control register |
| clk_run_o | output | 1 | Clock-running flag, low in SLEEP |
| cca_ok_o | output | 1 | Clear-channel reporting permitted |

## Verification
The critical collisions are a power-mode write that lands in the same cycle as an enable, and a new write that lands in the cycle in which a stored write would be applied. The bench provokes the first by writing STANDBY while raising TX enable in READY, and expects STANDBY rather than TRANSMIT. It provokes the second by leaving TRANSMIT with SLEEP stored and then writing STANDBY one cycle later. It expects STANDBY, and it expects STANDBY again in the following cycle, which shows that the stored SLEEP was dropped. A hard reset that arrives together with a stored request is judged by checking that the request is gone once reset completes.

// File: rtl/phy_pm_pkg.sv
package phy_pm_pkg;

  typedef enum logic [2:0] {
    ST_RESET   = 3'd0,
    ST_SLEEP   = 3'd1,
    ST_STANDBY = 3'd2,
    ST_READY   = 3'd3,
    ST_TX      = 3'd4,
    ST_RX      = 3'd5
  } pm_state_e;

  localparam logic [1:0] PM_READY   = 2'b00;
  localparam logic [1:0] PM_STANDBY = 2'b01;
  localparam logic [1:0] PM_SLEEP   = 2'b10;
  localparam logic [1:0] PM_BAD     = 2'b11;

  function automatic pm_state_e mode_to_state(input logic [1:0] m);
    case (m)
      PM_READY:   return ST_READY;
      PM_STANDBY: return ST_STANDBY;
      default:    return ST_SLEEP;
    endcase
  endfunction

endpackage

// File: rtl/phy_pm_rstseq.sv
module phy_pm_rstseq #(
  parameter int RST_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic phy_reset_i,
  input  logic in_reset_i,
  output logic done_o
);
  localparam int CW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;
  localparam logic [CW-1:0] LOAD = CW'(RST_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || phy_reset_i || !in_reset_i) cnt_q <= LOAD;
    else if (cnt_q != '0)                  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = in_reset_i && !phy_reset_i && (cnt_q == '0);

  AST_RST_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
    ((RST_CYC > 1) && in_reset_i && phy_reset_i) |=> !done_o); // R2

endmodule

// File: rtl/phy_pm_pmreq.sv
module phy_pm_pmreq
  import phy_pm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr_i,
  input  logic       wr_i,
  input  logic [1:0] mode_i,
  input  logic       can_apply_i,
  output logic       req_vld_o,
  output logic [1:0] req_mode_o
);
  logic       wr_ok;
  logic       pend_vld_q;
  logic [1:0] pend_mode_q;

  assign wr_ok = wr_i && (mode_i != PM_BAD) && !clr_i;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      pend_vld_q  <= 1'b0;
      pend_mode_q <= PM_READY;
    end else if (can_apply_i) begin
      pend_vld_q  <= 1'b0;
    end else if (wr_ok) begin
      pend_vld_q  <= 1'b1;
      pend_mode_q <= mode_i;
    end
  end

  assign req_vld_o  = can_apply_i && (wr_ok || pend_vld_q);
  assign req_mode_o = wr_ok ? mode_i : pend_mode_q;

  AST_PEND_KEEP: assert property (@(posedge clk) disable iff (rst)
    (pend_vld_q && !can_apply_i && !clr_i && !wr_ok) |=> (pend_vld_q && $stable(pend_mode_q))); // R8

  AST_NO_BAD_REQ: assert property (@(posedge clk) disable iff (rst)
    req_vld_o |-> (req_mode_o != PM_BAD)); // R6

endmodule

// File: rtl/phy_pm_cca.sv
module phy_pm_cca #(
  parameter int CCA_CYC = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic ccre_i,
  input  logic allow_i,
  output logic ok_o
);
  localparam int CW = $clog2(CCA_CYC + 1);
  localparam logic [CW-1:0] MAX = CW'(CCA_CYC);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    if (clr_i || !ccre_i)  cnt_n = '0;
    else if (cnt_q == MAX) cnt_n = MAX;
    else                   cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ok_o  <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      ok_o  <= (cnt_n == MAX) && allow_i;
    end
  end

  AST_CCA_DROP: assert property (@(posedge clk) disable iff (rst)
    !ccre_i |=> !ok_o); // R10

endmodule

// File: rtl/phy_pm_ctrl.sv
module phy_pm_ctrl
  import phy_pm_pkg::*;
#(
  parameter int RST_CYC = 16,
  parameter int CCA_CYC = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       phy_reset_i,
  input  logic       tx_en_i,
  input  logic       rx_en_i,
  input  logic       pm_wr_i,
  input  logic [1:0] pm_mode_i,
  input  logic       ccre_i,
  output logic [2:0] state_o,
  output logic       phy_active_o,
  output logic       rdy_o,
  output logic       clk_run_o,
  output logic       cca_ok_o
);
  pm_state_e  state_q, state_n;
  logic       hs_q, hs_n;
  logic       rst_done;
  logic       idle;
  logic       req_vld;
  logic [1:0] req_mode;
  logic       pm_clr;
  logic       cca_allow;

  assign idle   = ((state_q == ST_SLEEP) || (state_q == ST_STANDBY) ||
                   (state_q == ST_READY)) && !hs_q;
  assign pm_clr = phy_reset_i || (state_q == ST_RESET);

  phy_pm_rstseq #(.RST_CYC(RST_CYC)) u_rstseq (
    .clk        (clk),
    .rst        (rst),
    .phy_reset_i(phy_reset_i),
    .in_reset_i (state_q == ST_RESET),
    .done_o     (rst_done)
  );

  phy_pm_pmreq u_pmreq (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (pm_clr),
    .wr_i       (pm_wr_i),
    .mode_i     (pm_mode_i),
    .can_apply_i(idle),
    .req_vld_o  (req_vld),
    .req_mode_o (req_mode)
  );

  always_comb begin
    state_n = state_q;
    hs_n    = hs_q;
    if (phy_reset_i) begin
      state_n = ST_RESET;
      hs_n    = 1'b0;
    end else if (idle && req_vld) begin
      state_n = mode_to_state(req_mode);
    end else begin
      case (state_q)
        ST_RESET:   if (rst_done) state_n = ST_STANDBY;
        ST_SLEEP:   if (tx_en_i && rx_en_i) begin
                      state_n = ST_STANDBY;
                      hs_n    = 1'b1;
                    end
        ST_STANDBY: if (hs_q && !tx_en_i && !rx_en_i) hs_n = 1'b0;
        ST_READY:   if (tx_en_i && !rx_en_i)      state_n = ST_TX;
                    else if (rx_en_i && !tx_en_i) state_n = ST_RX;
        ST_TX:      if (!tx_en_i) state_n = ST_READY;
        ST_RX:      if (!rx_en_i) state_n = ST_READY;
        default:    state_n = ST_RESET;
      endcase
    end
  end

  assign cca_allow = (state_n == ST_READY) || (state_n == ST_RX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_RESET;
      hs_q         <= 1'b0;
      phy_active_o <= 1'b1;
      rdy_o        <= 1'b0;
      clk_run_o    <= 1'b1;
    end else begin
      state_q      <= state_n;
      hs_q         <= hs_n;
      phy_active_o <= (state_n == ST_RESET) || hs_n;
      clk_run_o    <= (state_n != ST_SLEEP);
      if (state_n == ST_RESET) rdy_o <= 1'b0;
      else if (rst_done)       rdy_o <= 1'b1;
    end
  end

  phy_pm_cca #(.CCA_CYC(CCA_CYC)) u_cca (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (state_n == ST_RESET),
    .ccre_i (ccre_i),
    .allow_i(cca_allow),
    .ok_o   (cca_ok_o)
  );

  assign state_o = state_q;

  AST_RST_FORCE: assert property (@(posedge clk) disable iff (rst)
    phy_reset_i |=> (state_q == ST_RESET && phy_active_o)); // R1

  AST_RDY_LOW: assert property (@(posedge clk) disable iff (rst)
    phy_reset_i |=> !rdy_o); // R3

  AST_WAKE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLEEP && tx_en_i && rx_en_i && !phy_reset_i && !pm_wr_i)
      |=> (state_q == ST_STANDBY && phy_active_o)); // R4

  AST_SLEEP_CLK: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLEEP) |-> !clk_run_o); // R4

  AST_TX_EXIT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TX && !tx_en_i && !phy_reset_i) |=> (state_q == ST_READY)); // R7

  AST_CCA_STATE: assert property (@(posedge clk) disable iff (rst)
    cca_ok_o |-> (state_q == ST_READY || state_q == ST_RX)); // R11

endmodule

// File: tb/sim_phy_pm_ctrl.sv
module sim_phy_pm_ctrl;
  localparam int RST_CYC = 4;
  localparam int CCA_CYC = 3;
  localparam int NV = 31;

  // {phy_reset, tx, rx, wr, mode[1:0], exp_state[2:0], exp_active}
  localparam logic [9:0] VEC [NV] = '{
    10'b0_0_0_1_00_011_0, 10'b0_1_0_0_00_100_0, 10'b0_1_0_1_01_100_0,
    10'b0_0_0_0_00_011_0, 10'b0_0_0_0_00_010_0, 10'b0_1_1_0_00_010_0,
    10'b0_0_0_1_10_001_0, 10'b0_1_0_0_00_001_0, 10'b0_1_1_0_00_010_1,
    10'b0_1_1_1_00_010_1, 10'b0_1_0_0_00_010_1, 10'b0_0_0_0_00_010_0,
    10'b0_0_0_0_00_011_0, 10'b0_0_1_0_00_101_0, 10'b0_1_1_0_00_101_0,
    10'b0_0_0_0_00_011_0, 10'b0_1_1_0_00_011_0, 10'b0_0_0_1_11_011_0,
    10'b0_1_0_1_01_010_0, 10'b0_0_0_1_00_011_0, 10'b0_0_1_0_00_101_0,
    10'b0_0_1_1_10_101_0, 10'b0_0_1_1_01_101_0, 10'b0_0_0_0_00_011_0,
    10'b0_0_0_0_00_010_0, 10'b0_0_0_1_00_011_0, 10'b0_1_0_0_00_100_0,
    10'b0_1_0_1_10_100_0, 10'b0_0_0_0_00_011_0, 10'b0_0_0_1_01_010_0,
    10'b0_0_0_0_00_010_0
  };

  logic clk = 1'b0;
  logic rst, phy_reset, tx_en, rx_en, pm_wr, ccre;
  logic [1:0] pm_mode;
  logic [2:0] state;
  logic phy_active, rdy, clk_run, cca_ok;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  phy_pm_ctrl #(.RST_CYC(RST_CYC), .CCA_CYC(CCA_CYC)) u0 (
    .clk(clk), .rst(rst), .phy_reset_i(phy_reset), .tx_en_i(tx_en),
    .rx_en_i(rx_en), .pm_wr_i(pm_wr), .pm_mode_i(pm_mode), .ccre_i(ccre),
    .state_o(state), .phy_active_o(phy_active), .rdy_o(rdy),
    .clk_run_o(clk_run), .cca_ok_o(cca_ok)
  );

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    pm_wr = 1'b0;
  endtask

  task automatic wr(input logic [1:0] m);
    pm_wr = 1'b1;
    pm_mode = m;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; phy_reset = 1'b0; tx_en = 1'b0; rx_en = 1'b0;
    pm_wr = 1'b0; pm_mode = 2'b00; ccre = 1'b0;
    @(negedge clk);
    step(); step(); step();
    rst = 1'b0;
    chk("R1 reset state", state, 0);
    chk("R1 reset active", phy_active, 1);
    chk("R3 reset rdy", rdy, 0);
    chk("R11 reset cca", cca_ok, 0);
    repeat (RST_CYC - 1) step();
    chk("R2 not early", state, 0);
    chk("R2 active held", phy_active, 1);
    step();
    chk("R2 standby", state, 2);
    chk("R2 active falls", phy_active, 0);
    chk("R3 rdy set", rdy, 1);

    for (int i = 0; i < NV; i++) begin
      phy_reset = VEC[i][9]; tx_en = VEC[i][8]; rx_en = VEC[i][7];
      pm_wr = VEC[i][6]; pm_mode = VEC[i][5:4];
      step();
      chk($sformatf("R6/R7/R8/R9 vec%0d state", i), state, int'(VEC[i][3:1]));
      chk($sformatf("R4/R5 vec%0d active", i), phy_active, int'(VEC[i][0]));
      chk($sformatf("R4 vec%0d clk_run", i), clk_run, int'(VEC[i][3:1] != 3'd1));
    end
    tx_en = 1'b0; rx_en = 1'b0;

    // CCA delay and state qualification (R10, R11)
    wr(2'b00); ccre = 1'b1;
    repeat (CCA_CYC - 1) step();
    chk("R10 cca not early", cca_ok, 0);
    step();
    chk("R10 cca on", cca_ok, 1);
    tx_en = 1'b1; step();
    chk("R11 cca off in tx", cca_ok, 0);
    tx_en = 1'b0; step();
    chk("R11 cca back in ready", cca_ok, 1);
    rx_en = 1'b1; step();
    chk("R11 cca in rx", cca_ok, 1);
    rx_en = 1'b0; step();
    ccre = 1'b0; step();
    chk("R10 cca drop", cca_ok, 0);
    ccre = 1'b1; wr(2'b01);
    repeat (CCA_CYC + 2) step();
    chk("R11 cca off in standby", cca_ok, 0);
    ccre = 1'b0;

    // Reset during transmit with a stored request (R1, R3, R6)
    wr(2'b00); step();
    tx_en = 1'b1; step();
    chk("R7 tx", state, 4);
    wr(2'b10); step();
    phy_reset = 1'b1; step();
    chk("R1 reset from tx", state, 0);
    chk("R1 active in reset", phy_active, 1);
    chk("R3 rdy cleared", rdy, 0);
    wr(2'b00); step();
    step();
    phy_reset = 1'b0; tx_en = 1'b0;
    repeat (RST_CYC - 1) step();
    chk("R2 still reset", state, 0);
    step();
    chk("R2 standby again", state, 2);
    chk("R3 rdy again", rdy, 1);
    step(); step();
    chk("R1 pending discarded", state, 2);
    chk("R6 reset write ignored", phy_active, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule